// File: doc/BRIEF.md
# Write-Back Ownership Coherence Controller

This block keeps the coherence state of a small direct-mapped, write-back private cache that sits on a shared snooping bus. Every line is invalid, read-only, or owned and writable. The local processor issues read, write and replace requests. The block watches the bus for the same three operations issued by other caches. From both sources it updates each line's state. It also drives the bus actions the protocol needs: an invalidation broadcast before the cache takes ownership, a write-back when owned data leaves the cache, and a data supply when another cache reads a block this cache owns.

The protocol is write-invalidate and has no exclusive-clean state. A local write always gains ownership through one invalidation broadcast. An owner that sees a remote read hands out its data, writes the data back in the same bus cycle, and drops to read-only. A line holds one data word. Backing memory is a register array inside the block. It answers at once, and write-backs update it. Snooped traffic takes the bus before any pending local action. Only one local request may be in flight at a time.

Top module: `own_coh_ctrl`

## Requirements
- R1: After reset every line reads back as invalid on `cpu_state`, `cpu_ready` is high, and `bus_inv`, `bus_wb` and `bus_supply` are low.
- R2: A local read of an invalid block completes with the memory word on `cpu_rdata` and leaves the block read-only. A local read of a valid block returns the cached word, keeps its state, and causes no bus traffic.
- R3: A local write to a block that is read-only or not present raises `bus_inv` for exactly one cycle, with the block address on `bus_addr`, and the block becomes read-write. A local write to a read-write block causes no bus traffic and keeps it read-write.
- R4: Operation codes on `cpu_op` and `snp_op` are 0 idle, 1 read, 2 write, 3 replace. State codes on `cpu_state` are 0 invalid, 1 read-only, 2 read-write.
- R5: A remote read of a read-write block raises `bus_supply` and `bus_wb` in the same cycle it arrives, with the block's word on `bus_data`. Memory takes that word and the block becomes read-only. A remote read of a read-only block changes nothing.
- R6: A remote write of a valid block makes it invalid, with no bus action from this cache.
- R7: A remote replace never changes any line state. A remote operation on a block this cache does not hold causes no bus action.
- R8: A local replace of a read-write block raises `bus_wb` for the block and leaves it invalid. Replacing a read-only block invalidates it with no bus traffic.
- R9: A local read or write that misses on an index held read-write by another block first writes that victim back (`bus_wb` with the victim's address), then proceeds as a miss.
- R10: While a local request is in progress `cpu_ready` is low, and no new request is accepted.
- R11: Any cycle with a snooped operation defers the pending local step. A deferred local request raises neither `bus_inv` nor `cpu_done` until the snoop input is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_op | input | 2 | Local operation code |
| cpu_addr | input | AW | Local block address; also selects the block shown on `cpu_state` |
| cpu_wdata | input | DW | Local write data |
| cpu_ready | output | 1 | High when a new local request can be accepted |
| cpu_done | output | 1 | High in the cycle a local request completes |
| cpu_rdata | output | DW | Read result, valid with `cpu_done` for reads |
| cpu_state | output | 2 | Coherence state of the block at `cpu_addr` |
| snp_op | input | 2 | Snooped remote operation code |
| snp_addr | input | AW | Snooped block address |
| bus_inv | output | 1 | Invalidation broadcast |
| bus_wb | output | 1 | Write-back to memory |
| bus_supply | output | 1 | Data supplied to a remote reader |
| bus_addr | output | AW | Address of the current bus action |
| bus_data | output | DW | Data of the current bus action |

## Verification
A corrupted line state shows at once on `cpu_state`, and on the bus in the very cycle of the next snoop that hits the block. A false owner raises `bus_supply` where none should appear. A missed ownership leaves a remote read silent. Lost or misdirected write-backs show up later, when a reload through `cpu_rdata` returns a stale memory word. So the bench sweeps every start state against every operation, then reads the block back through the normal read path.

// File: rtl/own_coh_ctrl.sv
module own_coh_ctrl #(
  parameter int LINES = 4,
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    cpu_op,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic          cpu_ready,
  output logic          cpu_done,
  output logic [DW-1:0] cpu_rdata,
  output logic [1:0]    cpu_state,
  input  logic [1:0]    snp_op,
  input  logic [AW-1:0] snp_addr,
  output logic          bus_inv,
  output logic          bus_wb,
  output logic          bus_supply,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_data
);
  localparam int IW = $clog2(LINES);
  localparam int TW = AW - IW;
  localparam int WORDS = 1 << AW;
  localparam logic [1:0] OP_NONE = 2'd0, OP_RD = 2'd1, OP_WR = 2'd2, OP_ZR = 2'd3;
  localparam logic [1:0] S_INV = 2'd0, S_RO = 2'd1, S_RW = 2'd2;

  logic [1:0]    st  [LINES];
  logic [TW-1:0] tg  [LINES];
  logic [DW-1:0] dat [LINES];
  logic [DW-1:0] mem [WORDS];

  logic          pend;
  logic [1:0]    p_op;
  logic [AW-1:0] p_addr;
  logic [DW-1:0] p_wdata;

  logic [IW-1:0] s_idx, p_idx, c_idx;
  logic [TW-1:0] s_tag, p_tag, c_tag;
  logic s_hit, s_sup, snoop_busy, p_hit, p_vict_rw, step, l_wb, l_inv;

  assign s_idx = snp_addr[IW-1:0];
  assign s_tag = snp_addr[AW-1:IW];
  assign p_idx = p_addr[IW-1:0];
  assign p_tag = p_addr[AW-1:IW];
  assign c_idx = cpu_addr[IW-1:0];
  assign c_tag = cpu_addr[AW-1:IW];

  assign snoop_busy = snp_op != OP_NONE;
  assign s_hit = st[s_idx] != S_INV && tg[s_idx] == s_tag;
  assign s_sup = snp_op == OP_RD && s_hit && st[s_idx] == S_RW;

  assign p_hit = st[p_idx] != S_INV && tg[p_idx] == p_tag;
  assign p_vict_rw = st[p_idx] == S_RW && !p_hit;
  assign step = pend && !snoop_busy;

  assign l_wb = step && (((p_op == OP_RD || p_op == OP_WR) && p_vict_rw) ||
                         (p_op == OP_ZR && p_hit && st[p_idx] == S_RW));
  assign l_inv = step && p_op == OP_WR && !(p_hit && st[p_idx] == S_RW) && !p_vict_rw;

  assign cpu_done  = step && !(p_op != OP_ZR && p_vict_rw);
  assign cpu_ready = !pend;
  assign cpu_rdata = p_hit ? dat[p_idx] : mem[p_addr];
  assign cpu_state = (st[c_idx] != S_INV && tg[c_idx] == c_tag) ? st[c_idx] : S_INV;

  assign bus_supply = s_sup;
  assign bus_wb     = s_sup || l_wb;
  assign bus_inv    = l_inv;
  assign bus_addr   = s_sup ? snp_addr : (l_wb ? {tg[p_idx], p_idx} : p_addr);
  assign bus_data   = s_sup ? dat[s_idx] : (l_inv ? p_wdata : dat[p_idx]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= 1'b0;
      p_op <= OP_NONE;
      p_addr <= '0;
      p_wdata <= '0;
      for (int i = 0; i < LINES; i++) begin
        st[i] <= S_INV;
        tg[i] <= '0;
        dat[i] <= '0;
      end
      for (int i = 0; i < WORDS; i++) mem[i] <= DW'(i * 37 + 5);
    end else begin
      if (!pend && cpu_op != OP_NONE) begin
        pend <= 1'b1;
        p_op <= cpu_op;
        p_addr <= cpu_addr;
        p_wdata <= cpu_wdata;
      end
      if (cpu_done) pend <= 1'b0;

      if (s_hit) begin
        if (s_sup) begin
          mem[snp_addr] <= dat[s_idx];
          st[s_idx] <= S_RO;
        end else if (snp_op == OP_WR) begin
          st[s_idx] <= S_INV;
        end
      end

      if (step) begin
        if (l_wb) begin
          mem[{tg[p_idx], p_idx}] <= dat[p_idx];
          st[p_idx] <= S_INV;
        end
        if (cpu_done) begin
          case (p_op)
            OP_RD: if (!p_hit) begin
              st[p_idx] <= S_RO;
              tg[p_idx] <= p_tag;
              dat[p_idx] <= mem[p_addr];
            end
            OP_WR: begin
              st[p_idx] <= S_RW;
              tg[p_idx] <= p_tag;
              dat[p_idx] <= p_wdata;
            end
            OP_ZR: if (p_hit) st[p_idx] <= S_INV;
            default: ;
          endcase
        end
      end
    end
  end

  p_bus_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bus_inv, bus_wb}));
  p_supply_wb_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_supply |-> bus_wb && bus_addr == snp_addr);
  p_snp_rd_ro_r5: assert property (@(posedge clk) disable iff (!rst_n)
    s_sup |=> st[$past(s_idx)] == S_RO);
  p_snp_wr_inv_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_op == OP_WR && s_hit) |=> st[$past(s_idx)] == S_INV);
  p_snp_z_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_op == OP_ZR) |=> st[$past(s_idx)] == $past(st[s_idx]));
  p_inv_to_rw_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_inv |=> st[$past(p_idx)] == S_RW);
  p_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ready && cpu_op != OP_NONE) |=> !cpu_ready);
  p_snoop_first_r11: assert property (@(posedge clk) disable iff (!rst_n)
    snoop_busy |-> !bus_inv && !cpu_done);
endmodule

// File: tb/own_coh_ctrl_test.sv
`timescale 1ns/1ps
module own_coh_ctrl_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] cpu_op = 2'd0, snp_op = 2'd0;
  logic [5:0] cpu_addr = '0, snp_addr = '0;
  logic [7:0] cpu_wdata = '0;
  logic cpu_ready, cpu_done, bus_inv, bus_wb, bus_supply;
  logic [7:0] cpu_rdata, bus_data;
  logic [1:0] cpu_state;
  logic [5:0] bus_addr;

  own_coh_ctrl #(.LINES(4), .AW(6), .DW(8)) uut (
    .clk(clk), .rst_n(rst_n), .cpu_op(cpu_op), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata), .cpu_state(cpu_state),
    .snp_op(snp_op), .snp_addr(snp_addr), .bus_inv(bus_inv), .bus_wb(bus_wb),
    .bus_supply(bus_supply), .bus_addr(bus_addr), .bus_data(bus_data));

  always #4 clk = ~clk;

  int errs = 0, checks = 0, cyc = 0;
  bit ended = 0;
  logic [7:0] mm [64];
  logic [7:0] md [64];
  logic [1:0] ms [64];

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !ended) begin
      ended = 1;
      errs++; checks++;
      $display("FAIL watchdog: actual=%0d cycles expected<=150000", cyc);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic local_op(input logic [1:0] op, input logic [5:0] a, input logic [7:0] wd,
                          output int ninv, output int nwb, output logic [7:0] rd,
                          output logic [5:0] wba);
    bit fin = 0;
    ninv = 0; nwb = 0; rd = '0; wba = '0;
    @(negedge clk); cpu_op = op; cpu_addr = a; cpu_wdata = wd;
    @(posedge clk); #1; cpu_op = 2'd0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (bus_inv) ninv++;
      if (bus_wb) begin nwb++; wba = bus_addr; end
      if (cpu_done) begin rd = cpu_rdata; fin = 1; break; end
    end
    chk(fin, "R10 local request completes", int'(fin), 1);
  endtask

  task automatic snoop(input logic [1:0] op, input logic [5:0] a,
                       output bit sup, output bit wb, output logic [7:0] d);
    @(negedge clk); snp_op = op; snp_addr = a; #1;
    sup = bus_supply; wb = bus_wb; d = bus_data;
    @(posedge clk); #1; snp_op = 2'd0;
  endtask

  task automatic get_st(input logic [5:0] a, output logic [1:0] s);
    @(negedge clk); cpu_addr = a; #1; s = cpu_state;
  endtask

  function automatic logic [1:0] nxt(input logic [1:0] s, input int op);
    case (op)
      0: return (s == 2'd0) ? 2'd1 : s;
      1: return 2'd2;
      2: return 2'd0;
      3: return (s == 2'd2) ? 2'd1 : s;
      4: return 2'd0;
      default: return s;
    endcase
  endfunction

  initial begin : main
    int ni, nw;
    logic [7:0] rd, d;
    logic [5:0] wa;
    logic [1:0] s;
    bit sp, wb;
    logic [5:0] alist [4];
    alist[0] = 6'd5; alist[1] = 6'd22; alist[2] = 6'd63; alist[3] = 6'd40;
    for (int i = 0; i < 64; i++) begin
      mm[i] = 8'(i * 37 + 5); ms[i] = 2'd0; md[i] = '0;
    end
    repeat (3) @(posedge clk);
    #1; rst_n = 1'b1;

    // R1: reset state
    @(negedge clk);
    chk(cpu_ready == 1'b1, "R1 ready after reset", int'(cpu_ready), 1);
    chk({bus_inv, bus_wb, bus_supply} == 3'b0, "R1 bus idle", int'({bus_inv, bus_wb, bus_supply}), 0);
    for (int i = 0; i < 4; i++) begin
      get_st(alist[i], s);
      chk(s == 2'd0, "R1 line invalid after reset", int'(s), 0);
    end

    // Exhaustive start-state x operation sweep (R2 R3 R4 R5 R6 R7 R8)
    for (int ai = 0; ai < 4; ai++) begin
      for (int st0 = 0; st0 < 3; st0++) begin
        for (int op = 0; op < 6; op++) begin
          logic [5:0] a;
          logic [7:0] wd, wd2;
          a = alist[ai];
          wd = a ^ 8'(8'h5A + st0 * 16 + op);
          wd2 = ~wd;
          local_op(2'd3, a, 8'h00, ni, nw, rd, wa);
          if (ms[a] == 2'd2) mm[a] = md[a];
          ms[a] = 2'd0;
          if (st0 == 1) begin
            local_op(2'd1, a, 8'h00, ni, nw, rd, wa);
            md[a] = mm[a]; ms[a] = 2'd1;
          end else if (st0 == 2) begin
            local_op(2'd2, a, wd, ni, nw, rd, wa);
            md[a] = wd; ms[a] = 2'd2;
          end
          case (op)
            0: begin
              local_op(2'd1, a, 8'h00, ni, nw, rd, wa);
              chk(rd == ((st0 == 0) ? mm[a] : md[a]), "R2 read data", int'(rd),
                  int'((st0 == 0) ? mm[a] : md[a]));
              chk(ni == 0 && nw == 0, "R2 read causes no bus traffic", ni + nw, 0);
              if (st0 == 0) md[a] = mm[a];
            end
            1: begin
              local_op(2'd2, a, wd2, ni, nw, rd, wa);
              chk(ni == ((st0 != 2) ? 1 : 0), "R3 invalidate count on write", ni, (st0 != 2) ? 1 : 0);
              chk(nw == 0, "R3 write causes no write-back", nw, 0);
              md[a] = wd2;
            end
            2: begin
              local_op(2'd3, a, 8'h00, ni, nw, rd, wa);
              chk(nw == ((st0 == 2) ? 1 : 0), "R8 replace write-back count", nw, (st0 == 2) ? 1 : 0);
              if (st0 == 2) begin
                chk(wa == a, "R8 write-back address", int'(wa), int'(a));
                mm[a] = md[a];
              end
            end
            3: begin
              snoop(2'd1, a, sp, wb, d);
              chk(sp == (st0 == 2) && wb == (st0 == 2), "R5 supply and write-back on remote read",
                  int'({sp, wb}), (st0 == 2) ? 3 : 0);
              if (st0 == 2) begin
                chk(d == md[a], "R5 supplied data", int'(d), int'(md[a]));
                mm[a] = md[a];
              end
            end
            4: begin
              snoop(2'd2, a, sp, wb, d);
              chk(!sp && !wb, "R6 remote write causes no bus action", int'({sp, wb}), 0);
            end
            default: begin
              snoop(2'd3, a, sp, wb, d);
              chk(!sp && !wb, "R7 remote replace causes no bus action", int'({sp, wb}), 0);
            end
          endcase
          ms[a] = nxt(2'(st0), op);
          get_st(a, s);
          chk(s == ms[a], "R4 state code after operation", int'(s), int'(ms[a]));
        end
      end
    end

    // R5: memory holds supplied word; reload through a fresh miss
    local_op(2'd3, 6'd22, 8'h00, ni, nw, rd, wa);
    if (ms[22] == 2'd2) mm[22] = md[22];
    local_op(2'd2, 6'd22, 8'hA5, ni, nw, rd, wa);
    snoop(2'd1, 6'd22, sp, wb, d);
    local_op(2'd3, 6'd22, 8'h00, ni, nw, rd, wa);
    chk(nw == 0, "R8 replacing read-only line has no write-back", nw, 0);
    local_op(2'd1, 6'd22, 8'h00, ni, nw, rd, wa);
    chk(rd == 8'hA5, "R5 memory updated by supply", int'(rd), 8'hA5);
    ms[22] = 2'd1; md[22] = 8'hA5; mm[22] = 8'hA5;

    // R7: remote ops on a block not held
    snoop(2'd1, 6'd26, sp, wb, d);
    chk(!sp && !wb, "R7 remote read of absent block", int'({sp, wb}), 0);
    get_st(6'd22, s);
    chk(s == 2'd1, "R7 neighbour line unchanged", int'(s), 1);

    // R9: conflict miss with read-write victim
    local_op(2'd3, 6'd5, 8'h00, ni, nw, rd, wa);
    if (ms[5] == 2'd2) mm[5] = md[5];
    local_op(2'd2, 6'd5, 8'hC3, ni, nw, rd, wa);
    local_op(2'd1, 6'd25, 8'h00, ni, nw, rd, wa);
    chk(nw == 1 && wa == 6'd5, "R9 victim write-back before read fill", int'(wa), 5);
    chk(rd == mm[25], "R9 fill data after eviction", int'(rd), int'(mm[25]));
    get_st(6'd5, s);
    chk(s == 2'd0, "R9 victim invalid", int'(s), 0);
    get_st(6'd25, s);
    chk(s == 2'd1, "R9 new block read-only", int'(s), 1);
    local_op(2'd1, 6'd5, 8'h00, ni, nw, rd, wa);
    chk(rd == 8'hC3 && nw == 0, "R9 victim data reached memory", int'(rd), 8'hC3);
    local_op(2'd2, 6'd25, 8'h3C, ni, nw, rd, wa);
    chk(ni == 1 && nw == 0, "R9 read-only victim dropped silently", ni * 10 + nw, 10);
    local_op(2'd2, 6'd5, 8'h11, ni, nw, rd, wa);
    chk(nw == 1 && wa == 6'd25 && ni == 1, "R9 write miss evicts owner then invalidates",
        int'(wa), 25);

    // R10 / R11: snoop traffic defers a pending local write
    local_op(2'd3, 6'd40, 8'h00, ni, nw, rd, wa);
    local_op(2'd3, 6'd22, 8'h00, ni, nw, rd, wa);
    local_op(2'd1, 6'd22, 8'h00, ni, nw, rd, wa);
    @(negedge clk);
    cpu_op = 2'd2; cpu_addr = 6'd22; cpu_wdata = 8'h77;
    snp_op = 2'd1; snp_addr = 6'd40;
    @(posedge clk); #1; cpu_op = 2'd1;
    for (int k = 0; k < 2; k++) begin
      @(negedge clk); #1;
      chk(!bus_inv && !cpu_done, "R11 local step deferred during snoop", int'({bus_inv, cpu_done}), 0);
      chk(!cpu_ready, "R10 ready low while pending", int'(cpu_ready), 0);
    end
    cpu_op = 2'd0;
    snp_op = 2'd0; #1;
    chk(bus_inv && cpu_done && bus_addr == 6'd22, "R11 invalidate once snoop idle",
        int'({bus_inv, cpu_done}), 3);
    @(posedge clk); #1;
    chk(cpu_ready, "R10 ready returns after completion", int'(cpu_ready), 1);
    get_st(6'd22, s);
    chk(s == 2'd2, "R3 line owned after deferred write", int'(s), 2);
    @(negedge clk); #1;
    chk(!bus_inv && !bus_wb && cpu_ready, "R10 read held during pend was not accepted",
        int'({bus_inv, bus_wb, cpu_ready}), 1);

    if (!ended) begin
      ended = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule